// File: doc/BRIEF.md
# Scanline Interrupt Detector with In-Frame Tracking

This block sits on the cartridge side of a video system. It infers scanline timing without a sync or blanking signal. It watches the per-cycle read and write strobes on both the CPU bus and the video (PPU) bus. It treats a run of identical video fetches in the upper address half as the start of a scanline. The CPU programs a target line number, and the block raises an active-low interrupt when its line counter reaches that number.

The block decides that the frame has ended in one of two ways. The first is a CPU fetch from either byte of the interrupt vector. The second is a short run of CPU reads with no video read between them, which shows that rendering has stopped. A status byte gives the pending-interrupt flag and the in-frame flag. Reading the status byte clears the pending flag. The bench and the integrator drive at most one bus strobe in any cycle.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset, the status byte is 0x00 and irq_n is high.
- R2: A video read is a detection when it is the third or a later read in a run of consecutive video reads that all carry the same 14-bit address, and that address has bit 13 set. The first detection while out of frame sets the in-frame flag, which is status bit 6.
- R3: Two identical consecutive video reads followed by a different address never produce a detection.
- R4: The reads in a run are compared on all 14 address bits. Three reads in which the first differs from the other two in any single bit produce no detection.
- R5: Identical consecutive reads whose address has bit 13 clear never produce a detection.
- R6: In an unbroken run of identical qualifying reads, each read after the third is a further detection. A run of N reads therefore gives N-2 detections.
- R7: A write to CPU address 0x5203 sets the target. The detection that enters the frame zeroes the line counter, and each later detection in the frame increments it. When the incremented value equals the target, the pending flag (status bit 7) is set.
- R8: A CPU read of 0x5204 returns the status byte, with bit 7 as pending, bit 6 as in-frame and bits 5..0 as zero. From the next cycle on, pending reads as 0.
- R9: irq_n is low exactly while pending is set and the enable bit is set. The enable bit is bit 7 of the last CPU write to 0x5204.
- R10: A CPU read of 0xFFFA or 0xFFFB clears the in-frame flag, and a status read in the cycle after it shows the flag clear. CPU writes to these addresses and a write of 0x00 to 0x2001 leave the flag set.
- R11: The third CPU read in a row with no video read between the reads clears the in-frame flag, and a status read in that same cycle already returns bit 6 as 0. Video writes and CPU writes do not break the run. A video read restarts it.
- R12: Leaving the frame discards the fetch-match history, so reads made before the frame ended do not count toward the next detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_rd | input | 1 | CPU read strobe for this cycle |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_rd | input | 1 | Video bus read strobe |
| ppu_wr | input | 1 | Video bus write strobe |
| ppu_addr | input | 14 | Video bus address |
| irq_n | output | 1 | Interrupt request, active low |
| status | output | 8 | Status byte as a read of 0x5204 in this cycle would return it |

## Verification
The bench sweeps the target through several values under two fetch patterns. In the first pattern each triple of reads is followed by a breaking read. In the second the reads run on without a break, which tests whether the design treats extra matching reads as further detections; a design that did not would report pending several lines late. It flips each address bit of the first read in a run in turn, so a design that compared only bit 13 would falsely enter the frame. It places CPU reads, CPU writes and video writes around the idle-run rule, so a design that cleared the flag one read late, or counted video writes as activity, would return 0x40 where 0x00 is due. It also ends a frame in the middle of a match run, so a design that kept the stale history would re-enter the frame after only one new read.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;
    localparam int BYTE_W = 8;
    localparam int CPU_AW = 16;

    localparam logic [CPU_AW-1:0] TARGET_ADDR = 16'h5203;
    localparam logic [CPU_AW-1:0] STATUS_ADDR = 16'h5204;
    localparam logic [CPU_AW-1:0] VEC_LO_ADDR = 16'hFFFA;
    localparam logic [CPU_AW-1:0] VEC_HI_ADDR = 16'hFFFB;

    typedef struct packed {
        logic              in_frame;
        logic              pending;
        logic              irq_en;
        logic [BYTE_W-1:0] target;
        logic [BYTE_W-1:0] line;
    } ctl_t;
endpackage

// File: rtl/fetch_repeat_matcher.sv
module fetch_repeat_matcher #(
    parameter int AW      = 14,
    parameter int HIT_BIT = 13,
    parameter int RUN     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic          flush,
    output logic          hit
);
    localparam int CW = $clog2(RUN + 1);
    localparam logic [CW-1:0] FULL = CW'(RUN - 1);

    typedef struct packed {
        logic [AW-1:0] last;
        logic [CW-1:0] run;
    } st_t;

    st_t st_d, st_q;
    logic same;

    always_comb begin
        st_d = st_q;
        same = (addr == st_q.last);
        hit  = rd && !flush && addr[HIT_BIT] && same && (st_q.run == FULL);
        if (flush) begin
            st_d.run = '0;
        end else if (rd) begin
            st_d.last = addr;
            if (same && st_q.run != '0)
                st_d.run = (st_q.run == FULL) ? FULL : st_q.run + 1'b1;
            else
                st_d.run = CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cpu_idle_tracker.sv
module cpu_idle_tracker #(
    parameter int N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_rd,
    input  logic ppu_rd,
    output logic idle
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        idle  = cpu_rd && (cnt_q == LAST);
        if (ppu_rd)
            cnt_d = '0;
        else if (cpu_rd && cnt_q != LAST)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
    import scanirq_pkg::*;
#(
    parameter int PPU_AW     = 14,
    parameter int NT_BIT     = 13,
    parameter int MATCH_LEN  = 3,
    parameter int IDLE_READS = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_rd,
    input  logic                    cpu_wr,
    input  logic [CPU_AW-1:0]       cpu_addr,
    input  logic [BYTE_W-1:0]       cpu_wdata,
    input  logic                    ppu_rd,
    input  logic                    ppu_wr,
    input  logic [PPU_AW-1:0]       ppu_addr,
    output logic                    irq_n,
    output logic [BYTE_W-1:0]       status
);
    ctl_t ctl_d, ctl_q;
    logic hit, idle, vec_rd, frame_end, live_frame;
    logic [BYTE_W-1:0] line_inc;

    fetch_repeat_matcher #(.AW(PPU_AW), .HIT_BIT(NT_BIT), .RUN(MATCH_LEN)) match_i (
        .clk(clk), .rst_n(rst_n), .rd(ppu_rd), .addr(ppu_addr),
        .flush(frame_end), .hit(hit)
    );

    cpu_idle_tracker #(.N(IDLE_READS)) idle_i (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .ppu_rd(ppu_rd), .idle(idle)
    );

    always_comb begin
        ctl_d      = ctl_q;
        vec_rd     = cpu_rd && (cpu_addr == VEC_LO_ADDR || cpu_addr == VEC_HI_ADDR);
        frame_end  = idle || vec_rd;
        live_frame = ctl_q.in_frame && !frame_end;
        line_inc   = ctl_q.line + 1'b1;
        status     = {ctl_q.pending, live_frame, {(BYTE_W-2){1'b0}}};
        irq_n      = !(ctl_q.pending && ctl_q.irq_en);

        if (cpu_wr && cpu_addr == TARGET_ADDR) ctl_d.target = cpu_wdata;
        if (cpu_wr && cpu_addr == STATUS_ADDR) ctl_d.irq_en = cpu_wdata[BYTE_W-1];
        if (cpu_rd && cpu_addr == STATUS_ADDR) ctl_d.pending = 1'b0;

        if (frame_end) begin
            ctl_d.in_frame = 1'b0;
            ctl_d.line     = '0;
        end else if (hit) begin
            if (!ctl_q.in_frame) begin
                ctl_d.in_frame = 1'b1;
                ctl_d.line     = '0;
            end else begin
                ctl_d.line = line_inc;
                if (line_inc == ctl_q.target) ctl_d.pending = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/scanirq_checks.sv
module scanirq_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [15:0] cpu_addr,
    input logic        ppu_rd,
    input logic [13:0] ppu_addr,
    input logic        irq_n,
    input logic [7:0]  status
);
    // R1: reset holds the outputs idle
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |-> (irq_n && status == 8'h00));

    // R9: interrupt line only low with a pending flag
    a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> status[7]);

    // R8: status read clears pending on the following cycle
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == 16'h5204 && !ppu_rd) |=> !status[7]);

    // R8: low status bits always zero
    a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[5:0] == 6'd0);

    // R10: vector fetch shows in-frame clear in that cycle
    a_r10_vector_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && (cpu_addr == 16'hFFFA || cpu_addr == 16'hFFFB)) |-> !status[6]);

    // R5: a fetch with bit 13 clear cannot enter the frame
    a_r5_low_half_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_rd && !ppu_addr[13] && !status[6]) |=> !status[6]);

    // R10: a CPU write never drops the frame flag by itself
    a_r10_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd && !ppu_rd && status[6]) |=> (status[6] || cpu_rd));
endmodule

bind scanline_irq_unit scanirq_checks chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
    .irq_n(irq_n), .status(status)
);

// File: tb/scanline_irq_unit_tb.sv
module scanline_irq_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [13:0] NT = 14'h2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, ppu_rd = 1'b0, ppu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [13:0] ppu_addr = '0;
    logic        irq_n;
    logic [7:0]  status;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanline_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ppu_rd(ppu_rd),
        .ppu_wr(ppu_wr), .ppu_addr(ppu_addr), .irq_n(irq_n), .status(status)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cpu_read(input logic [15:0] a, output logic [7:0] st, output logic irq);
        cpu_rd = 1'b1; cpu_addr = a;
        #1; st = status; irq = irq_n;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic ppu_read(input logic [13:0] a);
        ppu_rd = 1'b1; ppu_addr = a;
        @(negedge clk); ppu_rd = 1'b0;
    endtask

    task automatic ppu_write(input logic [13:0] a);
        ppu_wr = 1'b1; ppu_addr = a;
        @(negedge clk); ppu_wr = 1'b0;
    endtask

    // leave frame, clear history and pending, program target and enable
    task automatic setup(input logic [7:0] tgt, input logic en);
        logic [7:0] s; logic q;
        ppu_read(14'h0000);
        cpu_read(16'hFFFA, s, q);
        ppu_read(14'h0000);
        cpu_read(16'h5204, s, q);
        cpu_write(16'h5203, tgt);
        cpu_write(16'h5204, {en, 7'd0});
        ppu_read(14'h0000);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] s; logic q;
        @(negedge clk); #1;
        chk("R1 status", status, 8'h00);
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R2 R7 R8 R9: triples with a breaking read, target swept
        for (int t = 1; t <= 5; t++) begin
            logic [13:0] a;
            a = NT | 14'(t * 37);
            setup(8'(t), 1'b1);
            for (int i = 0; i <= t + 2; i++) begin
                logic [7:0] e;
                cpu_read(16'h5204, s, q);
                e = (i == 0) ? 8'h00 : (i == t + 1) ? 8'hC0 : 8'h40;
                chk("R2/R7/R8 status per line", s, e);
                chk("R9 irq_n enabled", {7'd0, q}, {7'd0, !(i == t + 1)});
                ppu_read(a); ppu_read(a); ppu_read(a); ppu_read(14'h0000);
            end
        end

        // R9: enable off keeps irq_n high even with pending
        setup(8'd1, 1'b0);
        for (int i = 0; i <= 3; i++) begin
            cpu_read(16'h5204, s, q);
            chk("R9 irq_n disabled", {7'd0, q}, 8'h01);
            chk("R9 status disabled", s, (i == 0) ? 8'h00 : (i == 2) ? 8'hC0 : 8'h40);
            ppu_read(NT); ppu_read(NT); ppu_read(NT); ppu_read(14'h0000);
        end

        // R6: unbroken runs of identical reads
        for (int t = 1; t <= 7; t++) begin
            int jt;
            jt = (t + 2) / 3;
            setup(8'(t), 1'b1);
            for (int i = 0; i <= jt + 2; i++) begin
                cpu_read(16'h5204, s, q);
                chk("R6 unbroken run", s, (i == 0) ? 8'h00 : (i == jt + 1) ? 8'hC0 : 8'h40);
                ppu_read(NT | 14'h0155); ppu_read(NT | 14'h0155); ppu_read(NT | 14'h0155);
            end
        end

        // R3: pairs never detect
        setup(8'd1, 1'b1);
        for (int i = 0; i < 6; i++) begin
            ppu_read(NT); ppu_read(NT); ppu_read(14'h0000);
            cpu_read(16'h5204, s, q);
            chk("R3 pair only", s, 8'h00);
        end

        // R4: each single-bit difference in the first read breaks the match
        setup(8'd1, 1'b1);
        for (int b = 0; b < 13; b++) begin
            ppu_read(NT | 14'(1 << b)); ppu_read(NT); ppu_read(NT); ppu_read(14'h0000);
            cpu_read(16'h5204, s, q);
            chk($sformatf("R4 bit %0d", b), s, 8'h00);
        end

        // R5: bit 13 clear never detects
        setup(8'd1, 1'b1);
        for (int i = 0; i < 4; i++) begin
            ppu_read(14'h0123); ppu_read(14'h0123); ppu_read(14'h0123); ppu_read(NT);
            cpu_read(16'h5204, s, q);
            chk("R5 low half", s, 8'h00);
        end

        // R10: vector writes and 2001 write keep frame, vector reads drop it
        for (int v = 0; v < 2; v++) begin
            setup(8'd50, 1'b1);
            ppu_read(NT); ppu_read(NT); ppu_read(NT);
            cpu_write(16'hFFFA, 8'h12); cpu_write(16'hFFFB, 8'h34); cpu_write(16'h2001, 8'h00);
            cpu_read(16'h5204, s, q);
            chk("R10 writes keep frame", s, 8'h40);
            ppu_read(14'h0000);
            cpu_read((v == 0) ? 16'hFFFA : 16'hFFFB, s, q);
            cpu_read(16'h5204, s, q);
            chk("R10 vector read ends frame", s, 8'h00);
        end

        // R11: idle CPU reads
        setup(8'd50, 1'b1);
        ppu_read(NT); ppu_read(NT); ppu_read(NT);
        cpu_read(16'h0000, s, q);
        cpu_read(16'h5204, s, q);
        chk("R11 second read keeps frame", s, 8'h40);
        cpu_read(16'h5204, s, q);
        chk("R11 third read drops frame", s, 8'h00);

        setup(8'd50, 1'b1);
        ppu_read(NT); ppu_read(NT); ppu_read(NT);
        cpu_read(16'h0000, s, q);
        ppu_write(NT);
        cpu_write(16'h0300, 8'h00);
        cpu_read(16'h0000, s, q);
        cpu_read(16'h5204, s, q);
        chk("R11 writes do not break run", s, 8'h00);

        setup(8'd50, 1'b1);
        ppu_read(NT); ppu_read(NT); ppu_read(NT);
        cpu_read(16'h0000, s, q);
        cpu_read(16'h0000, s, q);
        ppu_read(14'h0000);
        cpu_read(16'h0000, s, q);
        cpu_read(16'h5204, s, q);
        chk("R11 video read restarts run", s, 8'h40);

        // R12: frame end discards match history
        setup(8'd2, 1'b1);
        ppu_read(NT); ppu_read(NT); ppu_read(NT); ppu_read(14'h0000);
        ppu_read(NT); ppu_read(NT);
        cpu_read(16'hFFFA, s, q);
        ppu_read(NT);
        cpu_read(16'h5204, s, q);
        chk("R12 stale history ignored", s, 8'h00);
        ppu_read(NT); ppu_read(NT);
        cpu_read(16'h5204, s, q);
        chk("R12 fresh triple enters", s, 8'h40);
        ppu_read(14'h0000); ppu_read(NT); ppu_read(NT); ppu_read(NT);
        ppu_read(14'h0000); ppu_read(NT); ppu_read(NT); ppu_read(NT);
        cpu_read(16'h5204, s, q);
        chk("R12 count restarts at zero", s, 8'hC0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule